// File: doc/BRIEF.md
# Program Counter Sequencer with Exception Capture

This unit keeps the program counter of a multi-cycle processor core, along with the saved exception return address and the exception reason register. On every clock edge it may load a new program counter. The new value is chosen from four sources: the incremented address produced by the ALU, a branch target already latched in the ALU output register, a jump target built from the current PC and the instruction's 26-bit index field, or a fixed exception entry address.

The PC is loaded when the unconditional write strobe is high. It is also loaded when the conditional write strobe is high and the ALU reports a zero result, which is how a taken branch is completed. When the control sequencer detects a fault, it raises the exception strobes. The unit then saves the faulting instruction's address, which is the current PC minus four because fetch has already advanced the PC. It also saves a one-bit cause code.

Top module: `pc_seq_unit`

## Requirements
- R1: While reset is held, pc_q, epc_q and cause_q read zero. After reset is released, they stay zero until a write strobe is applied.
- R2: The PC is written on a clock edge only when `wr_uncond` is 1, or when `wr_cond` and `alu_zero` are both 1. Otherwise it holds its value.
- R3: `pc_src` = 2'b00 loads `alu_res` into the PC.
- R4: `pc_src` = 2'b01 loads `alu_out` (the branch target) into the PC.
- R5: `pc_src` = 2'b10 loads the jump target. The jump target is the old PC bits [31:28], followed by `instr_idx`[25:0], followed by two zero bits.
- R6: `pc_src` = 2'b11 loads the exception entry address 32'h8000_0180.
- R7: When `epc_wr` is 1, the EPC is loaded on that edge with the PC value present before the edge, minus 4. Otherwise the EPC holds its value.
- R8: When `cause_wr` is 1, bit 0 of the Cause register is loaded from `int_cause`, where 0 means an undefined instruction and 1 means arithmetic overflow. Otherwise bit 0 holds its value. Bits [31:1] of the Cause register always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_uncond | input | 1 | Unconditional PC write strobe |
| wr_cond | input | 1 | Conditional (branch) PC write strobe |
| alu_zero | input | 1 | ALU zero flag |
| pc_src | input | 2 | Next-PC source select |
| alu_res | input | 32 | Combinational ALU result |
| alu_out | input | 32 | Latched ALU output register |
| instr_idx | input | 26 | Instruction jump index field |
| epc_wr | input | 1 | EPC capture strobe |
| cause_wr | input | 1 | Cause capture strobe |
| int_cause | input | 1 | Cause code: 0 undefined, 1 overflow |
| pc_q | output | 32 | Program counter |
| epc_q | output | 32 | Exception program counter |
| cause_q | output | 32 | Cause register |

## Verification
The bench drives the conditional strobe with a zero flag of 0, so a design that ignored the zero flag would take the branch. It uses a PC whose upper nibble is nonzero during a jump. A design that dropped the nibble or left the index unshifted would then land on the wrong address. The bench also captures the EPC in the same cycle that the PC moves to the exception vector. A design that used the new PC, or the PC without subtracting four, would record the wrong return address. Finally, the bench checks that the Cause register keeps its value when `cause_wr` is low and that its upper bits read zero.

// File: rtl/pc_seq_unit.sv
module pc_seq_unit #(
  parameter int          XLEN     = 32,
  parameter int          IDXW     = 26,
  parameter logic [31:0] EXC_VEC  = 32'h8000_0180,
  parameter logic [31:0] RST_PC   = 32'h0000_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_uncond,
  input  logic            wr_cond,
  input  logic            alu_zero,
  input  logic [1:0]      pc_src,
  input  logic [XLEN-1:0] alu_res,
  input  logic [XLEN-1:0] alu_out,
  input  logic [IDXW-1:0] instr_idx,
  input  logic            epc_wr,
  input  logic            cause_wr,
  input  logic            int_cause,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] cause_q
);
  localparam int HIW = XLEN - IDXW - 2;

  logic            pc_en;
  logic [XLEN-1:0] jmp_tgt;
  logic [XLEN-1:0] pc_nxt;
  logic            cause_bit;

  assign pc_en   = wr_uncond | (wr_cond & alu_zero);
  assign jmp_tgt = {pc_q[XLEN-1 -: HIW], instr_idx, 2'b00};

  always_comb begin
    case (pc_src)
      2'b00:   pc_nxt = alu_res;
      2'b01:   pc_nxt = alu_out;
      2'b10:   pc_nxt = jmp_tgt;
      default: pc_nxt = EXC_VEC[XLEN-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= RST_PC[XLEN-1:0];
      epc_q     <= '0;
      cause_bit <= 1'b0;
    end else begin
      if (pc_en)    pc_q      <= pc_nxt;
      if (epc_wr)   epc_q     <= pc_q - XLEN'(4);
      if (cause_wr) cause_bit <= int_cause;
    end
  end

  assign cause_q = {{(XLEN-1){1'b0}}, cause_bit};

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(wr_uncond | (wr_cond & alu_zero)) |=> $stable(pc_q));
  p_branch_nz_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_cond && !alu_zero && !wr_uncond) |=> $stable(pc_q));
  p_vec_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_uncond && pc_src == 2'b11) |=> (pc_q == EXC_VEC[XLEN-1:0]));
  p_jmp_hi_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_uncond && pc_src == 2'b10) |=>
      (pc_q[XLEN-1 -: HIW] == $past(pc_q[XLEN-1 -: HIW]) && pc_q[1:0] == 2'b00));
  p_epc_r7: assert property (@(posedge clk) disable iff (rst)
    epc_wr |=> (epc_q + XLEN'(4) == $past(pc_q)));
  p_epc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !epc_wr |=> $stable(epc_q));
  p_cause_r8: assert property (@(posedge clk) disable iff (rst)
    cause_wr |=> (cause_q == {{(XLEN-1){1'b0}}, $past(int_cause)}));
  p_cause_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !cause_wr |=> $stable(cause_q));
endmodule

// File: tb/sim_pc_seq_unit.sv
`timescale 1ns/1ps
module sim_pc_seq_unit;
  logic        clk = 0, rst = 1;
  logic        wr_uncond = 0, wr_cond = 0, alu_zero = 0;
  logic [1:0]  pc_src = 0;
  logic [31:0] alu_res = 0, alu_out = 0;
  logic [25:0] instr_idx = 0;
  logic        epc_wr = 0, cause_wr = 0, int_cause = 0;
  logic [31:0] pc_q, epc_q, cause_q;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  pc_seq_unit u0 (.clk, .rst, .wr_uncond, .wr_cond, .alu_zero, .pc_src,
    .alu_res, .alu_out, .instr_idx, .epc_wr, .cause_wr, .int_cause,
    .pc_q, .epc_q, .cause_q);

  task automatic chk(input string req, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #5;
    wr_uncond = 0; wr_cond = 0; alu_zero = 0; epc_wr = 0; cause_wr = 0;
  endtask

  task automatic t_reset();
    rst = 1; repeat (2) @(posedge clk); #5;
    chk("R1 pc", pc_q, 0); chk("R1 epc", epc_q, 0); chk("R1 cause", cause_q, 0);
    rst = 0; step();
    chk("R1 pc after release", pc_q, 0);
  endtask

  task automatic t_sources();
    alu_res = 32'h0000_0004; pc_src = 2'b00; wr_uncond = 1; step();
    chk("R3 alu_res", pc_q, 32'h0000_0004);
    alu_out = 32'hF000_1230; pc_src = 2'b01; wr_uncond = 1; step();
    chk("R4 alu_out", pc_q, 32'hF000_1230);
    instr_idx = 26'h2AB_CDEF; pc_src = 2'b10; wr_uncond = 1; step();
    chk("R5 jump", pc_q, {4'hF, 26'h2AB_CDEF, 2'b00});
    pc_src = 2'b11; wr_uncond = 1; step();
    chk("R6 vector", pc_q, 32'h8000_0180);
  endtask

  task automatic t_cond();
    alu_out = 32'h0000_1000; pc_src = 2'b01;
    wr_cond = 1; alu_zero = 0; step();
    chk("R2 not-taken", pc_q, 32'h8000_0180);
    wr_cond = 1; alu_zero = 1; step();
    chk("R2 taken", pc_q, 32'h0000_1000);
    alu_zero = 1; step();
    chk("R2 zero only", pc_q, 32'h0000_1000);
    wr_uncond = 1; alu_res = 32'h0000_1004; pc_src = 2'b00; step();
    chk("R2 uncond", pc_q, 32'h0000_1004);
  endtask

  task automatic t_exc();
    epc_wr = 1; cause_wr = 1; int_cause = 1; wr_uncond = 1; pc_src = 2'b11; step();
    chk("R7 epc", epc_q, 32'h0000_1000);
    chk("R8 cause overflow", cause_q, 32'h1);
    chk("R6 vector on exc", pc_q, 32'h8000_0180);
    int_cause = 0; step();
    chk("R8 cause hold", cause_q, 32'h1);
    chk("R7 epc hold", epc_q, 32'h0000_1000);
    cause_wr = 1; int_cause = 0; epc_wr = 1; step();
    chk("R8 cause undef", cause_q, 32'h0);
    chk("R7 epc second", epc_q, 32'h8000_017C);
  endtask

  initial begin
    t_reset(); t_sources(); t_cond(); t_exc();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule